// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block sits behind the write strobe of a parallel NOR flash front end and watches every bus write, one clock cycle per write. Each write is an address and a data word. The block recognises the standard unlock-then-command sequences. When a sequence completes, it fires a one-cycle start pulse for word program, sector erase, block erase or chip erase, together with the target address and data. It also keeps the flags that steer reads toward the identification or query tables. Running the array operation and timing it are left to the logic around it. That logic reports an operation in progress on `busy`, and the decoder then disregards every write.

A sequence always opens with two unlock writes. A third write at the unlock address then either arms a program, opens the two-level erase path, or switches the read mode. Query mode can also be entered with a single short write, and either special read mode can be left with a single write. Any write that breaks a sequence drops the decoder back to plain array read.

Top module: `fcd_decoder`

## Requirements
- R1: After reset all four start pulses are 0, `tgt_addr` and `tgt_data` are 0, and both `id_mode` and `query_mode` are 0.
- R2: Writes of data 0xAA at address 0x5555, 0x55 at 0x2AAA, and 0xA0 at 0x5555 arm a program. The next write raises `prog_start` for one cycle, in the cycle after that write, with `tgt_addr`/`tgt_data` equal to that write's full address and data.
- R3: The erase path is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA. A sixth write of 0x10 at 0x5555 then pulses `chip_erase_start` with `tgt_addr` = 0.
- R4: A sixth write of 0x30 on the erase path, at any address, pulses `sect_erase_start`. `tgt_addr` is that address with bits 10..0 cleared (2048-word sectors).
- R5: A sixth write of 0x50 on the erase path, at any address, pulses `blk_erase_start`. `tgt_addr` is that address with bits 14..0 cleared (32768-word blocks).
- R6: After the two unlock writes, 0x90@0x5555 sets `id_mode` and 0x98@0x5555 sets `query_mode`. Each takes effect in the cycle after that write, and the two flags are never high together.
- R7: After the two unlock writes, 0xF0@0x5555 clears both mode flags. A single write of 0xF0 at any address, outside a sequence, also clears both.
- R8: A single write of 0x98 at address 0x0055, outside a sequence, sets `query_mode`.
- R9: A write that does not match the expected step returns the decoder to its start state and clears both mode flags. The next 0xAA@0x5555 begins a fresh sequence.
- R10: Only address bits 14..0 and data bits 7..0 take part in command matching; higher bits have no effect on decoding.
- R11: A write while `busy` is 1 is ignored: no start pulse, no mode change, and no advance or abort of a sequence in progress.
- R12: At most one start pulse is high in any cycle, and no start pulse stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One bus write is presented this cycle |
| wr_addr | input | ADDR_W (19) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| busy | input | 1 | Internal program or erase in progress |
| prog_start | output | 1 | One-cycle word program start |
| sect_erase_start | output | 1 | One-cycle sector erase start |
| blk_erase_start | output | 1 | One-cycle block erase start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| tgt_addr | output | ADDR_W (19) | Target address of the launched operation |
| tgt_data | output | DATA_W (16) | Data word of the launched operation |
| id_mode | output | 1 | Identification read mode active |
| query_mode | output | 1 | Query read mode active |

## Verification
The hardest situation to reach is a busy write that lands in the middle of a sequence. From the ports it looks like a sequence that was neither broken nor advanced. The bench inserts busy writes carrying mismatching data between the unlock steps, and again right after a program is armed. A correct decoder still launches the program from the next non-busy write, with that write's address. A second hard case is an abort just before a sixth erase write. The bench then checks that no pulse appears and that a fresh sequence written straight afterwards launches normally.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMD_AW = 15;
  localparam int CMD_DW = 8;

  localparam logic [CMD_AW-1:0] ADR_UNLK_A  = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_UNLK_B  = 15'h2AAA;
  localparam logic [CMD_AW-1:0] ADR_QRY_ONE = 15'h0055;

  localparam logic [CMD_DW-1:0] CODE_KEY_A = 8'hAA;
  localparam logic [CMD_DW-1:0] CODE_KEY_B = 8'h55;
  localparam logic [CMD_DW-1:0] CODE_PGM   = 8'hA0;
  localparam logic [CMD_DW-1:0] CODE_ERASE = 8'h80;
  localparam logic [CMD_DW-1:0] CODE_CHIP  = 8'h10;
  localparam logic [CMD_DW-1:0] CODE_SECT  = 8'h30;
  localparam logic [CMD_DW-1:0] CODE_BLK   = 8'h50;
  localparam logic [CMD_DW-1:0] CODE_IDENT = 8'h90;
  localparam logic [CMD_DW-1:0] CODE_QUERY = 8'h98;
  localparam logic [CMD_DW-1:0] CODE_LEAVE = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM_ARM, S_ERA1, S_ERA2, S_ERA3
  } seq_t;

  typedef enum logic [1:0] { M_ARRAY, M_IDENT, M_QUERY } mode_t;

  typedef enum logic [2:0] { OP_NONE, OP_PROG, OP_SECT, OP_BLK, OP_CHIP } op_t;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic at_q;
    logic k_aa;
    logic k_55;
    logic k_a0;
    logic k_80;
    logic k_10;
    logic k_30;
    logic k_50;
    logic k_90;
    logic k_98;
    logic k_f0;
  } hit_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
(
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [CMD_DW-1:0] cmd_data,
  output hit_t              hit
);

  always_comb begin
    hit.at_a = (cmd_addr == ADR_UNLK_A);
    hit.at_b = (cmd_addr == ADR_UNLK_B);
    hit.at_q = (cmd_addr == ADR_QRY_ONE);
    hit.k_aa = (cmd_data == CODE_KEY_A);
    hit.k_55 = (cmd_data == CODE_KEY_B);
    hit.k_a0 = (cmd_data == CODE_PGM);
    hit.k_80 = (cmd_data == CODE_ERASE);
    hit.k_10 = (cmd_data == CODE_CHIP);
    hit.k_30 = (cmd_data == CODE_SECT);
    hit.k_50 = (cmd_data == CODE_BLK);
    hit.k_90 = (cmd_data == CODE_IDENT);
    hit.k_98 = (cmd_data == CODE_QUERY);
    hit.k_f0 = (cmd_data == CODE_LEAVE);
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  hit_t  hit,
  output op_t   op_evt,
  output mode_t mode_q
);

  seq_t  st_q, st_n;
  mode_t md_n;

  always_comb begin
    st_n   = st_q;
    md_n   = mode_q;
    op_evt = OP_NONE;
    if (fire) begin
      // default outcome of any step is an abort to array read
      st_n = S_IDLE;
      md_n = M_ARRAY;
      case (st_q)
        S_IDLE: begin
          if (hit.at_a && hit.k_aa) begin
            st_n = S_UNL1;
            md_n = mode_q;
          end else if (hit.at_q && hit.k_98) begin
            md_n = M_QUERY;
          end
        end
        S_UNL1: begin
          if (hit.at_b && hit.k_55) begin
            st_n = S_UNL2;
            md_n = mode_q;
          end
        end
        S_UNL2: begin
          if (hit.at_a) begin
            if (hit.k_a0) begin
              st_n = S_PGM_ARM;
              md_n = mode_q;
            end else if (hit.k_80) begin
              st_n = S_ERA1;
              md_n = mode_q;
            end else if (hit.k_90) begin
              md_n = M_IDENT;
            end else if (hit.k_98) begin
              md_n = M_QUERY;
            end
          end
        end
        S_PGM_ARM: op_evt = OP_PROG;
        S_ERA1: begin
          if (hit.at_a && hit.k_aa) begin
            st_n = S_ERA2;
            md_n = mode_q;
          end
        end
        S_ERA2: begin
          if (hit.at_b && hit.k_55) begin
            st_n = S_ERA3;
            md_n = mode_q;
          end
        end
        S_ERA3: begin
          if (hit.at_a && hit.k_10)  op_evt = OP_CHIP;
          else if (hit.k_30)         op_evt = OP_SECT;
          else if (hit.k_50)         op_evt = OP_BLK;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      mode_q <= M_ARRAY;
    end else begin
      st_q   <= st_n;
      mode_q <= md_n;
    end
  end

endmodule

// File: rtl/fcd_launch.sv
module fcd_launch
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  op_t               op_evt,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic              prog_start,
  output logic              sect_erase_start,
  output logic              blk_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);

  localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    case (op_evt)
      OP_SECT: addr_n = src_addr & SECT_MASK;
      OP_BLK:  addr_n = src_addr & BLK_MASK;
      OP_CHIP: addr_n = '0;
      default: addr_n = src_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_start       <= 1'b0;
      sect_erase_start <= 1'b0;
      blk_erase_start  <= 1'b0;
      chip_erase_start <= 1'b0;
      tgt_addr         <= '0;
      tgt_data         <= '0;
    end else begin
      prog_start       <= (op_evt == OP_PROG);
      sect_erase_start <= (op_evt == OP_SECT);
      blk_erase_start  <= (op_evt == OP_BLK);
      chip_erase_start <= (op_evt == OP_CHIP);
      if (op_evt != OP_NONE) begin
        tgt_addr <= addr_n;
        tgt_data <= src_data;
      end
    end
  end

endmodule

// File: rtl/fcd_decoder.sv
module fcd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_start,
  output logic              sect_erase_start,
  output logic              blk_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              id_mode,
  output logic              query_mode
);

  hit_t  hit;
  op_t   op_evt;
  mode_t mode_q;
  logic  fire;

  assign fire = wr_en && !busy;

  fcd_match u_match (
    .cmd_addr (wr_addr[CMD_AW-1:0]),
    .cmd_data (wr_data[CMD_DW-1:0]),
    .hit      (hit)
  );

  fcd_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .hit    (hit),
    .op_evt (op_evt),
    .mode_q (mode_q)
  );

  fcd_launch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) u_launch (
    .clk              (clk),
    .rst              (rst),
    .op_evt           (op_evt),
    .src_addr         (wr_addr),
    .src_data         (wr_data),
    .prog_start       (prog_start),
    .sect_erase_start (sect_erase_start),
    .blk_erase_start  (blk_erase_start),
    .chip_erase_start (chip_erase_start),
    .tgt_addr         (tgt_addr),
    .tgt_data         (tgt_data)
  );

  assign id_mode    = (mode_q == M_IDENT);
  assign query_mode = (mode_q == M_QUERY);

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              busy,
  input logic              prog_start,
  input logic              sect_erase_start,
  input logic              blk_erase_start,
  input logic              chip_erase_start,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              id_mode,
  input logic              query_mode
);

  logic [3:0] starts;
  assign starts = {prog_start, sect_erase_start, blk_erase_start, chip_erase_start};

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(starts)); // R12

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (starts != 4'b0) |=> (starts == 4'b0)); // R12

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (starts == 4'b0)); // R11

  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> ($stable(id_mode) && $stable(query_mode))); // R11

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(id_mode && query_mode)); // R6

  AST_QUIET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((starts == 4'b0) && $stable(id_mode) && $stable(query_mode))); // R6

  AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    sect_erase_start |-> (tgt_addr[SECT_LSB-1:0] == '0)); // R4

  AST_BLK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    blk_erase_start |-> (tgt_addr[BLK_LSB-1:0] == '0)); // R5

  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (rst)
    chip_erase_start |-> (tgt_addr == '0)); // R3

endmodule

bind fcd_decoder fcd_chk #(
  .ADDR_W   (ADDR_W),
  .SECT_LSB (SECT_LSB),
  .BLK_LSB  (BLK_LSB)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .wr_en            (wr_en),
  .busy             (busy),
  .prog_start       (prog_start),
  .sect_erase_start (sect_erase_start),
  .blk_erase_start  (blk_erase_start),
  .chip_erase_start (chip_erase_start),
  .tgt_addr         (tgt_addr),
  .id_mode          (id_mode),
  .query_mode       (query_mode)
);

// File: tb/fcd_decoder_tb.sv
module fcd_decoder_tb;

  localparam int AW = 19;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic          id_mode, query_mode;

  always #4 clk = ~clk;

  fcd_decoder u_dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .busy (busy),
    .prog_start (prog_start), .sect_erase_start (sect_erase_start),
    .blk_erase_start (blk_erase_start), .chip_erase_start (chip_erase_start),
    .tgt_addr (tgt_addr), .tgt_data (tgt_data),
    .id_mode (id_mode), .query_mode (query_mode)
  );

  // kinds: 1 program, 2 sector, 3 block, 4 chip
  typedef struct {
    int            kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  bit   prev_pulse = 1'b0;

  task automatic note(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h05555, 16'h00AA, 0);
    wr(19'h02AAA, 16'h0055, 0);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(19'h05555, 16'h0080, 0);
    unlock();
  endtask

  task automatic expect_op(input int k, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk_mode(input bit e_id, input bit e_q, input string tag);
    note(id_mode == e_id, tag, "id_mode", id_mode, e_id);
    note(query_mode == e_q, tag, "query_mode", query_mode, e_q);
  endtask

  // monitor: compares every launched operation with the scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      automatic int cnt = int'(prog_start) + int'(sect_erase_start) +
                          int'(blk_erase_start) + int'(chip_erase_start);
      automatic int kind = prog_start ? 1 : sect_erase_start ? 2 :
                           blk_erase_start ? 3 : chip_erase_start ? 4 : 0;
      if (cnt != 0) begin
        note(cnt == 1, "R12", "simultaneous starts", cnt, 1);
        note(!prev_pulse, "R12", "start held two cycles", 1, 0);
        if (exp_q.size() == 0) begin
          note(1'b0, "R9", "unexpected start kind", kind, 0);
        end else begin
          automatic exp_t e = exp_q.pop_front();
          note(kind == e.kind, e.tag, "start kind", kind, e.kind);
          note(tgt_addr == e.addr, e.tag, "tgt_addr", tgt_addr, e.addr);
          if (e.kind == 1)
            note(tgt_data == e.data, e.tag, "tgt_data", tgt_data, e.data);
        end
      end
      prev_pulse = (cnt != 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    note({prog_start, sect_erase_start, blk_erase_start, chip_erase_start} == 4'b0,
         "R1", "starts after reset", 0, 0);
    note(tgt_addr == '0, "R1", "tgt_addr after reset", tgt_addr, 0);
    note(tgt_data == '0, "R1", "tgt_data after reset", tgt_data, 0);
    chk_mode(0, 0, "R1");

    // R2 word program
    unlock();
    wr(19'h05555, 16'h00A0, 0);
    expect_op(1, 19'h41234, 16'hBEEF, "R2");
    wr(19'h41234, 16'hBEEF, 0);

    // R10 upper address and data bits do not affect decoding
    wr(19'h7D555, 16'h12AA, 0);
    wr(19'h1AAAA, 16'hFF55, 0);
    wr(19'h45555, 16'h33A0, 0);
    expect_op(1, 19'h00010, 16'h0000, "R10");
    wr(19'h00010, 16'h0000, 0);

    // R3 chip erase
    erase_prefix();
    expect_op(4, 19'h00000, 16'h0, "R3");
    wr(19'h05555, 16'h0010, 0);

    // R4 sector erase
    erase_prefix();
    expect_op(2, 19'h2A800, 16'h0, "R4");
    wr(19'h2ABCD, 16'h0030, 0);

    // R5 block erase
    erase_prefix();
    expect_op(3, 19'h68000, 16'h0, "R5");
    wr(19'h6ABCD, 16'h0050, 0);

    // R6 / R7 mode entry and exit by three-write sequences
    unlock(); wr(19'h05555, 16'h0090, 0);
    chk_mode(1, 0, "R6");
    unlock(); wr(19'h05555, 16'h00F0, 0);
    chk_mode(0, 0, "R7");
    unlock(); wr(19'h05555, 16'h0098, 0);
    chk_mode(0, 1, "R6");
    wr(19'h12345, 16'h00F0, 0);
    chk_mode(0, 0, "R7");

    // R8 single-write query entry
    wr(19'h00055, 16'h0098, 0);
    chk_mode(0, 1, "R8");
    wr(19'h00000, 16'h00F0, 0);
    chk_mode(0, 0, "R7");

    // R9 abort clears mode, restart works
    unlock(); wr(19'h05555, 16'h0090, 0);
    chk_mode(1, 0, "R6");
    wr(19'h05555, 16'h00AA, 0);
    wr(19'h02AAA, 16'h0077, 0);
    chk_mode(0, 0, "R9");
    unlock(); wr(19'h05555, 16'h00A0, 0);
    expect_op(1, 19'h00321, 16'hA5A5, "R9");
    wr(19'h00321, 16'hA5A5, 0);
    // abort at sixth erase write: no start at all
    erase_prefix();
    wr(19'h05555, 16'h0020, 0);
    @(negedge clk);
    note(exp_q.size() == 0, "R9", "scoreboard after aborted erase", exp_q.size(), 0);

    // R11 busy writes ignored
    wr(19'h00055, 16'h0098, 0);
    chk_mode(0, 1, "R8");
    wr(19'h00000, 16'h00F0, 1);
    chk_mode(0, 1, "R11");
    wr(19'h05555, 16'h00AA, 0);
    wr(19'h00000, 16'h0000, 1);
    wr(19'h02AAA, 16'h0055, 0);
    wr(19'h05555, 16'h00A0, 0);
    wr(19'h00100, 16'h1111, 1);
    expect_op(1, 19'h00200, 16'h2222, "R11");
    wr(19'h00200, 16'h2222, 0);

    repeat (4) @(negedge clk);
    note(exp_q.size() == 0, "R12", "all expected starts seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule